// File: doc/BRIEF.md
# Extension-register and exception-PC legalizer

This block stores the machine ISA register and the machine exception-PC register of a RISC-V style hart whose compressed-instruction extension is optional. Software writes reach it over a plain single-cycle CSR port made of an address, a write enable, write data and combinational read data. Every write is legalized before it is stored, and the exception PC is masked on read according to the current compressed bit.

Two configuration straps control the behaviour. One selects whether the compressed extension is on after reset. The other decides whether the ISA register accepts writes at all. The fetch logic drives the next-PC input. The block drives the live compressed-enable bit back to fetch, and also drives the status-register width fields for the other privilege levels.

Every pin here is control or status, and there is no data stream. No pin therefore has a valid/ready handshake, and no pin can apply back-pressure. A write is accepted in the cycle it is presented and takes effect at the next rising clock edge.

Top module: `isa_csr_legalizer`

## Requirements
- R1: After a synchronous active-high reset, the ISA register has these values. Bits XLEN-1:XLEN-2 hold 2'b10 when XLEN is 64 and 2'b01 when XLEN is 32. The atomics (bit 0), base-integer (bit 8), multiply/divide (bit 12), supervisor (bit 18) and user (bit 20) bits are 1. Every other bit except bit 2 is 0. With XLEN 64 and bit 2 clear, the register reads 64'h8000_0000_0014_1101.
- R2: Bit 2 of the ISA register is the compressed bit. After reset it equals the `cfg_cmp_rst` strap, and `cmp_en` always reflects its current value.
- R3: When `cfg_isa_wr` is 0, a write to the ISA address leaves the register unchanged.
- R4: When `cfg_isa_wr` is 1, a write to the ISA address can change only bit 2. All other bits keep their current values, whatever the write data holds.
- R5: A write that would change bit 2 from 1 to 0 is dropped while `next_pc` bit 1 is 1. A write that sets bit 2 is never dropped.
- R6: When `cfg_isa_wr` is 1 or the compressed bit is 1, a write to the exception-PC address stores the write data with only bit 0 forced to 0.
- R7: When `cfg_isa_wr` is 0 and the compressed bit is 0, a write to the exception-PC address stores the write data with bits 1 and 0 forced to 0.
- R8: A read of the exception-PC address returns the stored value with bit 1 forced to 0 while the compressed bit is 0. It returns the stored value unchanged while the compressed bit is 1.
- R9: `sxl` and `uxl` both carry the same 2-bit width code as the top field of the ISA register. They do not change after reset.
- R10: The exception PC resets to 0. A write becomes visible on the read port from the cycle after it is presented, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cmp_rst | input | 1 | Compressed bit value loaded at reset |
| cfg_isa_wr | input | 1 | 1 lets the ISA register accept writes |
| next_pc | input | XLEN | Next fetch PC from the fetch logic |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | Write enable for the addressed CSR |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for csr_addr |
| cmp_en | output | 1 | Current compressed-enable bit |
| sxl | output | 2 | Supervisor width code |
| uxl | output | 2 | User width code |

## Verification
In one cycle, a write that clears the compressed bit can meet a `next_pc` whose bit 1 is set. The bench sets up this case by raising `next_pc` bit 1 in the same cycle as the write. It then reads back both registers to confirm that the compressed bit stayed 1 and that the exception PC is still returned unmasked. The bench repeats the write with `next_pc` bit 1 cleared. It then expects the compressed bit to fall and the next exception-PC read to lose bit 1. This second case shows that an ISA change and the read mask interact one cycle apart.

// File: rtl/isa_legal_pkg.sv
package isa_legal_pkg;
  localparam int BIT_ATOM = 0;
  localparam int BIT_CMP  = 2;
  localparam int BIT_BASE = 8;
  localparam int BIT_MUL  = 12;
  localparam int BIT_SUP  = 18;
  localparam int BIT_USR  = 20;

  function automatic logic [1:0] width_code(int xlen);
    return (xlen == 64) ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/isa_reg.sv
module isa_reg
  import isa_legal_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmp_rst,
  input  logic            wr_allow,
  input  logic            wr,
  input  logic [XLEN-1:0] wdata,
  input  logic            pc_half,
  output logic [XLEN-1:0] isa_q
);
  localparam logic [1:0] WCODE = width_code(XLEN);

  logic [XLEN-1:0] reset_val;
  logic            req_cmp;
  logic            refuse;
  logic [XLEN-1:0] nxt;

  always_comb begin
    reset_val              = '0;
    reset_val[XLEN-1:XLEN-2] = WCODE;
    reset_val[BIT_ATOM]    = 1'b1;
    reset_val[BIT_BASE]    = 1'b1;
    reset_val[BIT_MUL]     = 1'b1;
    reset_val[BIT_SUP]     = 1'b1;
    reset_val[BIT_USR]     = 1'b1;
    reset_val[BIT_CMP]     = cmp_rst;
  end

  always_comb begin
    req_cmp = wdata[BIT_CMP];
    refuse  = !req_cmp && pc_half;
    nxt     = isa_q;
    if (wr && wr_allow && !refuse) nxt[BIT_CMP] = req_cmp;
  end

  always_ff @(posedge clk) begin
    if (rst) isa_q <= reset_val;
    else     isa_q <= nxt;
  end

  a_r3_locked: assert property (@(posedge clk) disable iff (rst)
    (wr && !wr_allow) |=> $stable(isa_q));

  a_r4_others_fixed: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((isa_q & ~(XLEN'(1) << BIT_CMP)) == ($past(isa_q) & ~(XLEN'(1) << BIT_CMP))));

  a_r5_no_clear: assert property (@(posedge clk) disable iff (rst)
    (wr && wr_allow && pc_half && isa_q[BIT_CMP]) |=> isa_q[BIT_CMP]);
endmodule

// File: rtl/epc_reg.sv
module epc_reg #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_allow,
  input  logic            cmp,
  input  logic            wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rd_val
);
  logic [XLEN-1:0] epc_q;
  logic [XLEN-1:0] legal;

  always_comb begin
    legal    = wdata;
    legal[0] = 1'b0;
    if (!wr_allow && !cmp) legal[1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)     epc_q <= '0;
    else if (wr) epc_q <= legal;
  end

  always_comb begin
    rd_val = epc_q;
    if (!cmp) rd_val[1] = 1'b0;
  end

  a_r6_bit0_only: assert property (@(posedge clk) disable iff (rst)
    (wr && (wr_allow || cmp)) |=> (epc_q == {$past(wdata[XLEN-1:1]), 1'b0}));

  a_r7_both_low: assert property (@(posedge clk) disable iff (rst)
    (wr && !wr_allow && !cmp) |=> (epc_q[1:0] == 2'b00));

  a_r8_read_mask: assert property (@(posedge clk) disable iff (rst)
    !cmp |-> (rd_val[1] == 1'b0));
endmodule

// File: rtl/isa_csr_legalizer.sv
module isa_csr_legalizer
  import isa_legal_pkg::*;
#(
  parameter int          XLEN     = 64,
  parameter logic [11:0] ADDR_ISA = 12'h301,
  parameter logic [11:0] ADDR_EPC = 12'h341
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_cmp_rst,
  input  logic            cfg_isa_wr,
  input  logic [XLEN-1:0] next_pc,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            cmp_en,
  output logic [1:0]      sxl,
  output logic [1:0]      uxl
);
  localparam logic [1:0] WCODE = width_code(XLEN);

  logic            sel_isa, sel_epc;
  logic [XLEN-1:0] isa_val, epc_val;
  logic [1:0]      sxl_q, uxl_q;

  assign sel_isa = (csr_addr == ADDR_ISA);
  assign sel_epc = (csr_addr == ADDR_EPC);

  isa_reg #(.XLEN(XLEN)) u_isa (
    .clk(clk), .rst(rst), .cmp_rst(cfg_cmp_rst), .wr_allow(cfg_isa_wr),
    .wr(csr_we && sel_isa), .wdata(csr_wdata), .pc_half(next_pc[1]),
    .isa_q(isa_val)
  );

  epc_reg #(.XLEN(XLEN)) u_epc (
    .clk(clk), .rst(rst), .wr_allow(cfg_isa_wr), .cmp(isa_val[BIT_CMP]),
    .wr(csr_we && sel_epc), .wdata(csr_wdata), .rd_val(epc_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sxl_q <= WCODE;
      uxl_q <= WCODE;
    end
  end

  always_comb begin
    if (sel_isa)      csr_rdata = isa_val;
    else if (sel_epc) csr_rdata = epc_val;
    else              csr_rdata = '0;
  end

  assign cmp_en = isa_val[BIT_CMP];
  assign sxl    = sxl_q;
  assign uxl    = uxl_q;

  a_r9_width_match: assert property (@(posedge clk) disable iff (rst)
    (sxl == isa_val[XLEN-1:XLEN-2]) && (uxl == isa_val[XLEN-1:XLEN-2]));
endmodule

// File: tb/isa_csr_legalizer_tb_top.sv
module isa_csr_legalizer_tb_top;
  localparam int XLEN = 64;
  localparam logic [11:0] A_ISA = 12'h301;
  localparam logic [11:0] A_EPC = 12'h341;
  localparam logic [63:0] ISA0 = 64'h8000_0000_0014_1101;
  localparam logic [63:0] ISA1 = 64'h8000_0000_0014_1105;

  logic clk = 0, rst = 1, cfg_cmp_rst = 0, cfg_isa_wr = 0, csr_we = 0;
  logic [XLEN-1:0] next_pc = '0, csr_wdata = '0, csr_rdata;
  logic [11:0] csr_addr = '0;
  logic cmp_en;
  logic [1:0] sxl, uxl;

  always #5 clk = ~clk;

  isa_csr_legalizer #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .cfg_cmp_rst(cfg_cmp_rst), .cfg_isa_wr(cfg_isa_wr),
    .next_pc(next_pc), .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .cmp_en(cmp_en), .sxl(sxl), .uxl(uxl)
  );

  int errors = 0, checks = 0;
  bit probe = 0, done = 0;
  logic [63:0] q_exp[$];
  int          q_kind[$];
  string       q_tag[$];

  // kind: 0 rdata, 1 cmp_en, 2 sxl, 3 uxl
  task automatic expect_item(input logic [11:0] addr, input int kind,
                             input logic [63:0] exp, input string tag);
    @(posedge clk); #1;
    csr_addr = addr; csr_we = 0;
    q_exp.push_back(exp); q_kind.push_back(kind); q_tag.push_back(tag);
    probe = 1;
    @(posedge clk); #1;
    probe = 0;
  endtask

  task automatic csr_write(input logic [11:0] addr, input logic [63:0] data);
    @(posedge clk); #1;
    csr_addr = addr; csr_wdata = data; csr_we = 1;
    @(posedge clk); #1;
    csr_we = 0;
  endtask

  task automatic do_reset(input logic c, input logic w);
    @(posedge clk); #1;
    rst = 1; cfg_cmp_rst = c; cfg_isa_wr = w;
    repeat (2) @(posedge clk);
    #1 rst = 0;
  endtask

  always @(negedge clk) begin
    if (probe && q_exp.size() > 0) begin
      logic [63:0] e, a;
      int k;
      string t;
      e = q_exp.pop_front(); k = q_kind.pop_front(); t = q_tag.pop_front();
      case (k)
        0: a = csr_rdata;
        1: a = {63'd0, cmp_en};
        2: a = {62'd0, sxl};
        default: a = {62'd0, uxl};
      endcase
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", t, a, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Phase 1: compressed off at reset, ISA not writable
    do_reset(1'b0, 1'b0);
    expect_item(A_ISA, 0, ISA0, "R1 reset isa");
    expect_item(A_ISA, 1, 64'd0, "R2 cmp_en from strap 0");
    expect_item(A_ISA, 2, 64'd2, "R9 sxl");
    expect_item(A_ISA, 3, 64'd2, "R9 uxl");
    expect_item(A_EPC, 0, 64'd0, "R10 epc reset");
    csr_write(A_ISA, '1);
    expect_item(A_ISA, 0, ISA0, "R3 write ignored");
    csr_write(A_EPC, 64'h1237);
    expect_item(A_EPC, 0, 64'h1234, "R7 both low bits cleared");
    expect_item(12'h7C0, 0, 64'd0, "R10 unmapped read");

    // Phase 2: compressed on at reset, ISA writable
    do_reset(1'b1, 1'b1);
    expect_item(A_ISA, 0, ISA1, "R2 reset isa with cmp");
    expect_item(A_ISA, 1, 64'd1, "R2 cmp_en from strap 1");
    csr_write(A_EPC, 64'h1237);
    expect_item(A_EPC, 0, 64'h1236, "R6 bit0 cleared, R8 unmasked");
    next_pc = 64'h1002;
    csr_write(A_ISA, 64'd0);
    expect_item(A_ISA, 0, ISA1, "R5 clear refused on half-aligned pc");
    expect_item(A_EPC, 0, 64'h1236, "R8 still unmasked after refused clear");
    next_pc = 64'h1004;
    csr_write(A_ISA, 64'd0);
    expect_item(A_ISA, 0, ISA0, "R4 only cmp bit cleared");
    expect_item(A_ISA, 1, 64'd0, "R2 cmp_en follows clear");
    expect_item(A_EPC, 0, 64'h1234, "R8 bit1 masked");
    csr_write(A_EPC, 64'h5673);
    expect_item(A_EPC, 0, 64'h5670, "R6 writable keeps bit1 stored, R8 masked");
    next_pc = 64'h2002;
    csr_write(A_ISA, '1);
    expect_item(A_ISA, 0, ISA1, "R4 set cmp only, R5 set never refused");
    expect_item(A_EPC, 0, 64'h5672, "R8 unmasked again, R6 bit1 kept");
    expect_item(A_ISA, 2, 64'd2, "R9 sxl stable");

    // Phase 3: compressed on, ISA not writable
    do_reset(1'b1, 1'b0);
    expect_item(A_EPC, 0, 64'd0, "R10 epc reset again");
    csr_write(A_EPC, 64'h3);
    expect_item(A_EPC, 0, 64'h2, "R6 cmp on keeps bit1");
    next_pc = 64'h0;
    csr_write(A_ISA, 64'd0);
    expect_item(A_ISA, 0, ISA1, "R3 locked clear ignored");

    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule